// File: doc/BRIEF.md
# Divider-Step Frequency Table Generator

This block builds the list of feedback-divider settings that one clock cluster's PLL may use, each paired with the output frequency in kHz that the setting gives. A controller loads five values with a one-cycle `start` pulse: the reference clock in Hz, the post divider, the input divider, and the lowest and highest feedback divider. The block then works out a step size. It walks the divider range in that step and sends each entry over a valid/ready stream. A closing end-marker beat follows the entries.

All arithmetic is sequential. One shift-add multiplier and one restoring divider are shared by every stage. The stages are the reference scaling to kHz, the step computation, and the per-entry frequency. As a result, each entry costs a few dozen cycles and no wide combinational datapath is needed. The step is always a whole multiple of the input divider. The highest divider is always the final entry, whether or not it lands on a step.

Top module: `fdt_table_gen`

## Requirements
- R1: After reset, `ent_valid`, `busy` and `err` are low.
- R2: The step is `mdiv * ceil(50_000_000 / ref_hz)`, computed in integers.
- R3: The first entry has `ent_ndiv = ndiv_min`. Each next entry adds the step, as long as the result is strictly below `ndiv_max`.
- R4: The last real entry carries `ent_ndiv = ndiv_max` with `ent_last = 1`, even when `ndiv_max` is off the step grid. All earlier entries carry `ent_last = 0`.
- R5: Each entry's `ent_khz` equals `((ref_hz / 1000) * ndiv) / (pdiv * mdiv)`, with each division truncating.
- R6: When `ndiv_min == ndiv_max`, exactly one entry is produced.
- R7: Right after the last entry is accepted, an end-marker beat is offered: `ent_valid = 1`, `ent_end = 1`, `ent_last = 0`, `ent_ndiv = 0`.
- R8: While `ent_valid` is high and `ent_ready` is low, `ent_valid` stays high and all entry fields stay unchanged.
- R9: A start with `ref_hz == 0`, `pdiv == 0`, `mdiv == 0` or `ndiv_min > ndiv_max` sets `err`, produces no beats and leaves `busy` low. The next valid start clears `err`.
- R10: A `start` pulse while `busy` is high is ignored: the running table continues unchanged and `err` is not touched.
- R11: `busy` rises in the cycle after an accepted start and falls in the same edge that accepts the end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that latches the inputs below |
| ref_hz | input | 32 | Reference clock frequency in Hz |
| pdiv | input | 8 | Post divider |
| mdiv | input | 8 | Input divider |
| ndiv_min | input | 16 | Lowest feedback divider |
| ndiv_max | input | 16 | Highest feedback divider |
| ent_ready | input | 1 | Consumer accepts the current beat |
| ent_valid | output | 1 | A beat is offered |
| ent_ndiv | output | 16 | Feedback divider of the entry |
| ent_khz | output | 48 | Frequency of the entry in kHz |
| ent_last | output | 1 | Marks the final real entry |
| ent_end | output | 1 | Marks the end-marker beat |
| busy | output | 1 | A table is being produced |
| err | output | 1 | The last start carried illegal inputs |

## Verification
Several directed patterns are run. A 408 MHz reference gives a unit step and a dense, aligned walk. A 38.4 MHz reference with input divider 3 gives a step of 6 and a range whose top is off the grid, which shows that the forced final entry differs from plain stepping. Equal bounds give the single-entry case, and each illegal divisor or inverted range checks that no beat appears. Random references, dividers and spans from a fixed seed are then compared beat by beat against a bench model, under random backpressure, and a start is injected in mid-table to show it is ignored.

// File: rtl/fdt_pkg.sv
package fdt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KDIV,
    ST_SDIV,
    ST_SMUL,
    ST_EMUL,
    ST_EDIV,
    ST_EMIT,
    ST_END
  } fdt_state_t;
endpackage

// File: rtl/fdt_div.sv
module fdt_div #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    shifted, diff;

  assign shifted = {rem_q, quo[W-1]};
  assign diff    = shifted - {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      den_q <= '0;
      quo   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q <= '0;
        den_q <= den;
        quo   <= num;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!diff[W]) begin
          rem_q <= diff[W-1:0];
          quo   <= {quo[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo   <= {quo[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fdt_mul.sv
module fdt_mul #(
  parameter int W  = 48,
  parameter int NB = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [W-1:0]  a,
  input  logic [NB-1:0] b,
  output logic          done,
  output logic [W-1:0]  prod
);
  localparam int CW = $clog2(NB + 1);

  logic [W-1:0]  a_q;
  logic [NB-1:0] b_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      prod  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        a_q   <= a;
        b_q   <= b;
        prod  <= '0;
        cnt_q <= CW'(NB);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (b_q[0]) prod <= prod + a_q;
        a_q   <= a_q << 1;
        b_q   <= b_q >> 1;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fdt_table_gen.sv
module fdt_table_gen
  import fdt_pkg::*;
#(
  parameter int REF_W   = 32,
  parameter int DIV_W   = 8,
  parameter int NDIV_W  = 16,
  parameter int STEP_HZ = 50_000_000,
  parameter int KHZ_DIV = 1000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [REF_W-1:0]        ref_hz,
  input  logic [DIV_W-1:0]        pdiv,
  input  logic [DIV_W-1:0]        mdiv,
  input  logic [NDIV_W-1:0]       ndiv_min,
  input  logic [NDIV_W-1:0]       ndiv_max,
  input  logic                    ent_ready,
  output logic                    ent_valid,
  output logic [NDIV_W-1:0]       ent_ndiv,
  output logic [REF_W+NDIV_W-1:0] ent_khz,
  output logic                    ent_last,
  output logic                    ent_end,
  output logic                    busy,
  output logic                    err
);
  localparam int PW = REF_W + NDIV_W;

  fdt_state_t st_q;
  logic [REF_W-1:0]   r_ref;
  logic [DIV_W-1:0]   r_mdiv;
  logic [NDIV_W-1:0]  r_max, ndiv_q;
  logic [2*DIV_W-1:0] pm_q;
  logic [PW-1:0]      refk_q, step_q;
  logic               last_sel;

  logic          div_go, div_done, mul_go, mul_done;
  logic [PW-1:0] div_num, div_den, div_q, mul_a, mul_p;
  logic [NDIV_W-1:0] mul_b;

  logic          bad_in;
  logic [PW:0]   nxt_ndiv;
  logic          nxt_below;

  assign bad_in    = (ref_hz == '0) || (pdiv == '0) || (mdiv == '0) ||
                     (ndiv_min > ndiv_max);
  assign nxt_ndiv  = (PW+1)'(ndiv_q) + (PW+1)'(step_q);
  assign nxt_below = nxt_ndiv < (PW+1)'(r_max);

  fdt_div #(.W(PW)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
    .done(div_done), .quo(div_q)
  );

  fdt_mul #(.W(PW), .NB(NDIV_W)) u_mul (
    .clk(clk), .rst(rst), .go(mul_go), .a(mul_a), .b(mul_b),
    .done(mul_done), .prod(mul_p)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      r_ref     <= '0;
      r_mdiv    <= '0;
      r_max     <= '0;
      ndiv_q    <= '0;
      pm_q      <= '0;
      refk_q    <= '0;
      step_q    <= '0;
      last_sel  <= 1'b0;
      div_go    <= 1'b0;
      div_num   <= '0;
      div_den   <= '0;
      mul_go    <= 1'b0;
      mul_a     <= '0;
      mul_b     <= '0;
      ent_valid <= 1'b0;
      ent_ndiv  <= '0;
      ent_khz   <= '0;
      ent_last  <= 1'b0;
      ent_end   <= 1'b0;
      busy      <= 1'b0;
      err       <= 1'b0;
    end else begin
      div_go <= 1'b0;
      mul_go <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          if (bad_in) begin
            err <= 1'b1;
          end else begin
            err     <= 1'b0;
            busy    <= 1'b1;
            r_ref   <= ref_hz;
            r_mdiv  <= mdiv;
            r_max   <= ndiv_max;
            ndiv_q  <= ndiv_min;
            pm_q    <= (2*DIV_W)'(pdiv) * (2*DIV_W)'(mdiv);
            div_num <= PW'(ref_hz);
            div_den <= PW'(KHZ_DIV);
            div_go  <= 1'b1;
            st_q    <= ST_KDIV;
          end
        end
        ST_KDIV: if (div_done) begin
          refk_q  <= div_q;
          div_num <= PW'(STEP_HZ) + PW'(r_ref) - PW'(1);
          div_den <= PW'(r_ref);
          div_go  <= 1'b1;
          st_q    <= ST_SDIV;
        end
        ST_SDIV: if (div_done) begin
          mul_a  <= div_q;
          mul_b  <= NDIV_W'(r_mdiv);
          mul_go <= 1'b1;
          st_q   <= ST_SMUL;
        end
        ST_SMUL: if (mul_done) begin
          step_q   <= mul_p;
          last_sel <= (ndiv_q >= r_max);
          mul_a    <= refk_q;
          mul_b    <= ndiv_q;
          mul_go   <= 1'b1;
          st_q     <= ST_EMUL;
        end
        ST_EMUL: if (mul_done) begin
          div_num <= mul_p;
          div_den <= PW'(pm_q);
          div_go  <= 1'b1;
          st_q    <= ST_EDIV;
        end
        ST_EDIV: if (div_done) begin
          ent_valid <= 1'b1;
          ent_ndiv  <= ndiv_q;
          ent_khz   <= div_q;
          ent_last  <= last_sel;
          st_q      <= ST_EMIT;
        end
        ST_EMIT: if (ent_ready) begin
          if (last_sel) begin
            ent_end  <= 1'b1;
            ent_last <= 1'b0;
            ent_ndiv <= '0;
            ent_khz  <= '0;
            st_q     <= ST_END;
          end else begin
            ent_valid <= 1'b0;
            mul_a     <= refk_q;
            mul_go    <= 1'b1;
            st_q      <= ST_EMUL;
            if (nxt_below) begin
              ndiv_q <= nxt_ndiv[NDIV_W-1:0];
              mul_b  <= nxt_ndiv[NDIV_W-1:0];
            end else begin
              ndiv_q   <= r_max;
              mul_b    <= r_max;
              last_sel <= 1'b1;
            end
          end
        end
        ST_END: if (ent_ready) begin
          ent_valid <= 1'b0;
          ent_end   <= 1'b0;
          busy      <= 1'b0;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fdt_table_gen_chk.sv
module fdt_table_gen_chk #(
  parameter int NDIV_W = 16,
  parameter int KHZ_W  = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              ent_ready,
  input logic              ent_valid,
  input logic [NDIV_W-1:0] ent_ndiv,
  input logic [KHZ_W-1:0]  ent_khz,
  input logic              ent_last,
  input logic              ent_end,
  input logic              busy,
  input logic              err
);
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_ndiv) &&
      $stable(ent_khz) && $stable(ent_last) && $stable(ent_end)));

  a_r7_end_follows_last: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && ent_ready && ent_last) |=> (ent_valid && ent_end));

  a_r7_end_beat_clean: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && ent_end) |-> (!ent_last && ent_ndiv == '0));

  a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
    err |-> (!ent_valid && !busy));

  a_r11_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
    ent_valid |-> busy);

  a_r11_busy_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(ent_valid && ent_end && ent_ready));
endmodule

bind fdt_table_gen fdt_table_gen_chk #(
  .NDIV_W(NDIV_W),
  .KHZ_W (REF_W + NDIV_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ent_ready(ent_ready),
  .ent_valid(ent_valid),
  .ent_ndiv (ent_ndiv),
  .ent_khz  (ent_khz),
  .ent_last (ent_last),
  .ent_end  (ent_end),
  .busy     (busy),
  .err      (err)
);

// File: tb/fdt_table_gen_test.sv
module fdt_table_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] ref_hz = '0;
  logic [7:0]  pdiv = '0, mdiv = '0;
  logic [15:0] ndiv_min = '0, ndiv_max = '0;
  logic        ent_ready = 1'b0;
  logic        ent_valid, ent_last, ent_end, busy, err;
  logic [15:0] ent_ndiv;
  logic [47:0] ent_khz;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  fdt_table_gen uut (
    .clk(clk), .rst(rst), .start(start), .ref_hz(ref_hz), .pdiv(pdiv),
    .mdiv(mdiv), .ndiv_min(ndiv_min), .ndiv_max(ndiv_max),
    .ent_ready(ent_ready), .ent_valid(ent_valid), .ent_ndiv(ent_ndiv),
    .ent_khz(ent_khz), .ent_last(ent_last), .ent_end(ent_end),
    .busy(busy), .err(err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned model_khz(longint unsigned rf,
      longint unsigned p, longint unsigned m, longint unsigned n);
    return ((rf / 1000) * n) / (p * m);
  endfunction

  function automatic longint unsigned model_step(longint unsigned rf,
      longint unsigned m);
    return m * ((64'd50000000 + rf - 1) / rf);
  endfunction

  bit          stall_prev = 0;
  logic [15:0] s_ndiv;
  logic [47:0] s_khz;
  logic        s_last, s_end;

  task automatic get_beat(output logic [15:0] n, output logic [47:0] k,
                          output logic l, output logic e);
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (stall_prev)
        chk(ent_valid && ent_ndiv == s_ndiv && ent_khz == s_khz &&
            ent_last == s_last && ent_end == s_end, "R8 stall hold",
            longint'(ent_ndiv), longint'(s_ndiv));
      ent_ready = ($urandom % 4) != 0;
      if (ent_valid && ent_ready) begin
        n = ent_ndiv; k = ent_khz; l = ent_last; e = ent_end;
        stall_prev = 0;
        return;
      end
      stall_prev = ent_valid && !ent_ready;
      s_ndiv = ent_ndiv; s_khz = ent_khz; s_last = ent_last; s_end = ent_end;
    end
  endtask

  task automatic run_case(input int unsigned rf, input int unsigned p,
                          input int unsigned m, input int unsigned mn,
                          input int unsigned mx, input bit poke);
    longint unsigned step, cur, nxt;
    bit lastf;
    int cnt;
    logic [15:0] n;
    logic [47:0] k;
    logic l, e;
    @(negedge clk);
    ref_hz = rf; pdiv = 8'(p); mdiv = 8'(m);
    ndiv_min = 16'(mn); ndiv_max = 16'(mx);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (rf == 0 || p == 0 || m == 0 || mn > mx) begin
      cnt = 0;
      for (int i = 0; i < 20; i++) begin
        if (ent_valid || busy) cnt++;
        @(negedge clk);
      end
      chk(err && cnt == 0, "R9 illegal inputs", longint'(cnt), 0);
      return;
    end
    chk(busy && !err, "R11 busy after start R9 err cleared",
        longint'({busy, err}), 2);
    step = model_step(rf, m);
    cur = mn; lastf = (mn >= mx); cnt = 0;
    forever begin
      get_beat(n, k, l, e);
      cnt++;
      if (poke && cnt == 1) begin
        ref_hz = 1; pdiv = 0; mdiv = 0; ndiv_min = 0; ndiv_max = 0;
        start = 1'b1;
      end
      chk(n == cur && !e, "R2 R3 R4 entry ndiv", longint'(n), longint'(cur));
      chk(k == model_khz(rf, p, m, cur), "R5 entry khz",
          longint'(k), longint'(model_khz(rf, p, m, cur)));
      chk(l == lastf, "R4 last flag", longint'(l), longint'(lastf));
      if (lastf) break;
      nxt = cur + step;
      if (nxt < mx) cur = nxt;
      else begin cur = mx; lastf = 1; end
    end
    if (mn == mx) chk(cnt == 1, "R6 single entry", cnt, 1);
    get_beat(n, k, l, e);
    chk(e && !l && n == 0, "R7 end marker", longint'({e, l}), 2);
    @(negedge clk);
    ent_ready = 1'b0;
    chk(!busy && !ent_valid, "R11 busy drops after end",
        longint'(busy), 0);
    if (poke) chk(!err, "R10 start while busy ignored", longint'(err), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!ent_valid && !busy && !err, "R1 reset state",
        longint'({ent_valid, busy, err}), 0);
    rst = 1'b0;
    run_case(408000000, 1, 1, 100, 110, 0);
    run_case(38400000, 2, 3, 10, 27, 1);
    run_case(19200000, 1, 2, 50, 50, 0);
    run_case(25000000, 0, 1, 10, 20, 0);
    run_case(25000000, 1, 0, 10, 20, 0);
    run_case(0, 1, 1, 10, 20, 0);
    run_case(25000000, 1, 1, 30, 20, 0);
    run_case(12000000, 3, 1, 7, 40, 0);
    for (int t = 0; t < 12; t++) begin
      int unsigned rf, p, m, mn, mx;
      rf = 20000000 + ($urandom % 480000000);
      p  = 1 + ($urandom % 4);
      m  = 1 + ($urandom % 4);
      mn = 1 + ($urandom % 1000);
      mx = mn + ($urandom % 81);
      run_case(rf, p, m, mn, mx, (t % 4) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule